// File: doc/BRIEF.md
# UART Receive Byte Queue

This block is the receive-side holding buffer of a UART. A deserializer hands it complete bytes, and a line-condition detector hands it break events. The queue keeps up to four bytes in arrival order. The register interface sees the oldest byte on `head_data` and removes it with a one-cycle `pop`. The block produces the data-ready and queue-full status flags. It also drives an accept signal that throttles the deserializer, and a one-cycle break pulse that sets the break-change interrupt.

A break is stored as a zero byte. Ordinary data is refused once the queue is full. A break, by contrast, is never lost: on a full queue with no pop in the same cycle, it overwrites the most recently stored byte. A receiver-reset flush discards everything at once. Storage is a small circular buffer with read and write pointers, so a pop never moves data between slots.

Top module: `uart_rx_queue`

## Requirements
- R1: After synchronous reset, `count` is 0, `rdy`, `full` and `brk_det` are 0, `head_data` is 0x00, and `can_accept` follows `rx_en`.
- R2: Bytes leave in the order they were stored. `head_data` always shows the oldest stored byte, and a pop removes that byte at the next clock edge.
- R3: `count` gives the number of stored bytes, from 0 to 4. `rdy` is 1 whenever `count` is at least 1, and `full` is 1 exactly when `count` is 4. All three are registered.
- R4: While the queue is empty, `head_data` reads 0x00. A pop on an empty queue changes no state.
- R5: A pop that removes a byte, with no break in the same cycle, always leaves `full` at 0. `rdy` falls only when the last byte is removed.
- R6: `can_accept` is 1 only when `rx_en` is 1 and `full` is 0. A data push (`push_vld`) in a cycle where `can_accept` is 0 is discarded.
- R7: A break event (`brk_evt`) stores a 0x00 byte whether or not `rx_en` is set. It also raises `brk_det` for exactly the next cycle.
- R8: A break on a full queue, with no pop in that cycle, replaces the newest stored byte with 0x00. `count` stays at 4 and the older three bytes are unchanged.
- R9: A data push and a pop in the same cycle leave `count` unchanged when the queue holds 1 to 3 bytes. On an empty queue the pop is ignored and the pushed byte is stored.
- R10: `flush` empties the queue and clears `rdy` and `full` at the next edge. Any push, break store or pop in the same cycle is discarded.
- R11: When a break and a data push arrive in the same cycle, only the 0x00 break byte is stored.
- R12: A break together with a pop on a full queue removes the oldest byte and appends 0x00. `count` stays at 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| push_vld | input | 1 | Deserializer delivers a byte this cycle |
| push_data | input | WIDTH | Byte from the deserializer |
| brk_evt | input | 1 | Break condition detected this cycle |
| pop | input | 1 | Register interface consumes the head byte |
| flush | input | 1 | Receiver-reset command: discard all contents |
| head_data | output | WIDTH | Oldest stored byte, 0 when empty |
| count | output | $clog2(DEPTH+1) | Number of stored bytes |
| rdy | output | 1 | At least one byte stored |
| full | output | 1 | Queue holds DEPTH bytes |
| can_accept | output | 1 | Deserializer may push this cycle |
| brk_det | output | 1 | One-cycle pulse after a break event |

## Verification
The assertions assume that `push_vld`, `brk_evt`, `pop` and `flush` are single-cycle qualifiers sampled on the rising edge. They also assume a well-behaved deserializer pushes only while `can_accept` is high. Even so, the properties keep holding when a push arrives against a low `can_accept`, because that push must then leave `count` untouched. The stimulus changes every input on the falling edge and holds it through the next rising edge. It deliberately pushes into a full queue and into a disabled receiver to show that such pushes are discarded. Break, pop, push and flush are combined in the same cycle only in the patterns that R8 to R12 define.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Kind of storage write performed in a cycle
  typedef enum logic [1:0] {
    WR_NONE      = 2'd0,
    WR_APPEND    = 2'd1,
    WR_OVERWRITE = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/rxq_store.sv
// Slot memory: synchronous write, asynchronous read (distributed RAM)
module rxq_store #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_ctrl.sv
// Pointer, occupancy and flag control for the receive queue
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          push_vld,
  input  logic          brk_evt,
  input  logic          pop,
  input  logic          flush,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] count,
  output logic          rdy,
  output logic          full,
  output logic          brk_det
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          rdy_q, full_q, brk_q;
  logic          pop_ok, push_ok, append;
  wr_kind_e      kind;

  // A pop needs a stored byte; flush overrides all traffic
  assign pop_ok  = pop & rdy_q & ~flush;
  assign push_ok = push_vld & rx_en & ~full_q & ~brk_evt & ~flush;

  always_comb begin
    kind = WR_NONE;
    if (!flush) begin
      if (brk_evt)
        kind = (full_q && !pop_ok) ? WR_OVERWRITE : WR_APPEND;
      else if (push_ok)
        kind = WR_APPEND;
    end
  end

  assign append  = (kind == WR_APPEND);
  assign wr_en   = (kind != WR_NONE);
  assign wr_addr = (kind == WR_OVERWRITE) ? (wr_q - AW'(1)) : wr_q;
  assign rd_addr = rd_q;

  assign cnt_nxt = cnt_q + CW'(append) - CW'(pop_ok);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      rdy_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (pop_ok) rd_q <= rd_q + AW'(1);
      if (append) wr_q <= wr_q + AW'(1);
      cnt_q  <= cnt_nxt;
      rdy_q  <= (cnt_nxt != '0);
      full_q <= (cnt_nxt == CNT_MAX);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) brk_q <= 1'b0;
    else     brk_q <= brk_evt;
  end

  assign count   = cnt_q;
  assign rdy     = rdy_q;
  assign full    = full_q;
  assign brk_det = brk_q;
endmodule

// File: rtl/uart_rx_queue.sv
// UART receive byte queue: top level
module uart_rx_queue #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             push_vld,
  input  logic [WIDTH-1:0] push_data,
  input  logic             brk_evt,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] head_data,
  output logic [CW-1:0]    count,
  output logic             rdy,
  output logic             full,
  output logic             can_accept,
  output logic             brk_det
);
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [WIDTH-1:0] wdata, rdata;

  // A break is stored as an all-zero byte
  assign wdata = brk_evt ? '0 : push_data;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rx_en    (rx_en),
    .push_vld (push_vld),
    .brk_evt  (brk_evt),
    .pop      (pop),
    .flush    (flush),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .count    (count),
    .rdy      (rdy),
    .full     (full),
    .brk_det  (brk_det)
  );

  rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wdata),
    .raddr (rd_addr),
    .rdata (rdata)
  );

  assign head_data  = rdy ? rdata : '0;
  assign can_accept = rx_en & ~full;
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_en,
  input logic             push_vld,
  input logic             brk_evt,
  input logic             pop,
  input logic             flush,
  input logic [WIDTH-1:0] head_data,
  input logic [CW-1:0]    count,
  input logic             rdy,
  input logic             full,
  input logic             can_accept,
  input logic             brk_det
);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CMAX); // R3
  AST_RDY_TRACKS: assert property (@(posedge clk) disable iff (rst)
    rdy == (count != '0)); // R3
  AST_FULL_TRACKS: assert property (@(posedge clk) disable iff (rst)
    full == (count == CMAX)); // R3
  AST_EMPTY_HEAD: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> (head_data == '0)); // R4
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && pop && !push_vld && !brk_evt) |=> (count == '0)); // R4
  AST_POP_UNFULL: assert property (@(posedge clk) disable iff (rst)
    (pop && count != '0 && !brk_evt && !flush) |=> !full); // R5
  AST_ACCEPT_GATE: assert property (@(posedge clk) disable iff (rst)
    (!rx_en || full) |-> !can_accept); // R6
  AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (rst)
    (full && push_vld && !brk_evt && !pop && !flush) |=> $stable(count)); // R6
  AST_BRK_PULSE: assert property (@(posedge clk) disable iff (rst)
    brk_evt |=> brk_det); // R7
  AST_BRK_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    (full && brk_evt && !flush) |=> (count == CMAX)); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0 && !rdy && !full)); // R10
endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rx_en      (rx_en),
  .push_vld   (push_vld),
  .brk_evt    (brk_evt),
  .pop        (pop),
  .flush      (flush),
  .head_data  (head_data),
  .count      (count),
  .rdy        (rdy),
  .full       (full),
  .can_accept (can_accept),
  .brk_det    (brk_det)
);

// File: tb/uart_rx_queue_bench.sv
`timescale 1ns/1ps
module uart_rx_queue_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0, push_vld = 1'b0, brk_evt = 1'b0, pop = 1'b0, flush = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic [7:0] head_data;
  logic [2:0] count;
  logic       rdy, full, can_accept, brk_det;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] exp_q [$];   // scoreboard of bytes expected out of the queue

  always #10 clk = ~clk;   // 50 MHz

  uart_rx_queue u_uart_rx_queue (
    .clk(clk), .rst(rst), .rx_en(rx_en), .push_vld(push_vld), .push_data(push_data),
    .brk_evt(brk_evt), .pop(pop), .flush(flush), .head_data(head_data), .count(count),
    .rdy(rdy), .full(full), .can_accept(can_accept), .brk_det(brk_det)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver + monitor for one cycle. Called just after a falling edge.
  task automatic step(input logic p, input logic [7:0] d, input logic b,
                      input logic po, input logic f, input string req);
    int  sz;
    logic was_full, pop_ok;
    push_vld = p; push_data = d; brk_evt = b; pop = po; flush = f;
    #1;
    sz = exp_q.size();
    was_full = (sz == 4);
    chk(can_accept === (rx_en && !was_full), "R6 can_accept", int'(can_accept), int'(rx_en && !was_full));
    if (sz == 0) chk(head_data === 8'h00, "R4 empty head", int'(head_data), 0);
    else         chk(head_data === exp_q[0], {req, " head"}, int'(head_data), int'(exp_q[0]));
    // expected effect, from the requirements
    if (f) exp_q.delete();
    else begin
      pop_ok = po && (sz > 0);
      if (pop_ok) void'(exp_q.pop_front());
      if (b) begin
        if (was_full && !pop_ok) exp_q[3] = 8'h00;
        else exp_q.push_back(8'h00);
      end else if (p && rx_en && !was_full) exp_q.push_back(d);
    end
    @(posedge clk);
    @(negedge clk);
    push_vld = 1'b0; brk_evt = 1'b0; pop = 1'b0; flush = 1'b0;
    #1;
    chk(int'(count) == exp_q.size(), {req, " count"}, int'(count), exp_q.size());
    chk(rdy === (exp_q.size() != 0), "R3 rdy", int'(rdy), int'(exp_q.size() != 0));
    chk(full === (exp_q.size() == 4), "R3 full", int'(full), int'(exp_q.size() == 4));
    chk(brk_det === b, "R7 brk_det", int'(brk_det), int'(b));
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "idle");
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(count === 3'd0, "R1 count", int'(count), 0);
    chk(rdy === 1'b0 && full === 1'b0, "R1 flags", int'({rdy, full}), 0);
    chk(head_data === 8'h00, "R1 head", int'(head_data), 0);
    chk(brk_det === 1'b0, "R1 brk_det", int'(brk_det), 0);
    chk(can_accept === 1'b0, "R1 can_accept", int'(can_accept), 0);
    rx_en = 1'b1;
    #1;
    chk(can_accept === 1'b1, "R1 can_accept en", int'(can_accept), 1);

    // R2 order, R5 rdy falls only at zero
    step(1, 8'hA1, 0, 0, 0, "R2");
    step(1, 8'hB2, 0, 0, 0, "R2");
    step(1, 8'hC3, 0, 0, 0, "R2");
    step(0, 8'h00, 0, 1, 0, "R5");
    step(0, 8'h00, 0, 1, 0, "R5");
    step(0, 8'h00, 0, 1, 0, "R5");
    // R4 pop on empty
    step(0, 8'h00, 0, 1, 0, "R4");

    // R3 fill, R6 drop when full, R5 pop clears full
    step(1, 8'h11, 0, 0, 0, "R3");
    step(1, 8'h22, 0, 0, 0, "R3");
    step(1, 8'h33, 0, 0, 0, "R3");
    step(1, 8'h44, 0, 0, 0, "R3");
    step(1, 8'h55, 0, 0, 0, "R6");
    step(0, 8'h00, 0, 1, 0, "R5");
    // R9 push+pop mid-fill keeps count
    step(1, 8'h66, 0, 1, 0, "R9");
    step(0, 8'h00, 0, 1, 0, "R2");
    step(0, 8'h00, 0, 1, 0, "R2");
    step(0, 8'h00, 0, 1, 0, "R2");
    // R9 push+pop on empty stores the byte
    step(1, 8'h77, 0, 1, 0, "R9");
    step(0, 8'h00, 0, 1, 0, "R9");

    // R6 disabled receiver drops data; R7 break still stored
    rx_en = 1'b0;
    step(1, 8'h88, 0, 0, 0, "R6");
    step(0, 8'h00, 1, 0, 0, "R7");
    idle();
    rx_en = 1'b1;
    // R8 overwrite newest on full
    step(1, 8'h91, 0, 0, 0, "R8");
    step(1, 8'h92, 0, 0, 0, "R8");
    step(1, 8'h93, 0, 0, 0, "R8");
    step(0, 8'h00, 1, 0, 0, "R8");
    // R12 break + pop on full
    step(0, 8'h00, 1, 1, 0, "R12");
    step(0, 8'h00, 0, 1, 0, "R8");
    step(0, 8'h00, 0, 1, 0, "R8");
    step(0, 8'h00, 0, 1, 0, "R12");
    step(0, 8'h00, 0, 1, 0, "R12");
    // R11 break and push together
    step(1, 8'hEE, 1, 0, 0, "R11");
    step(0, 8'h00, 0, 1, 0, "R11");

    // R10 flush discards same-cycle push
    step(1, 8'h01, 0, 0, 0, "R10");
    step(1, 8'h02, 0, 0, 0, "R10");
    step(1, 8'h03, 0, 1, 1, "R10");
    step(0, 8'h00, 0, 1, 0, "R10");

    // mixed traffic
    lf = 8'h5A;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      rx_en = (lf[6:5] != 2'b00);
      step(lf[0], lf ^ 8'h3C, (lf[3:1] == 3'b101), lf[2] & lf[4],
           (lf == 8'h0F), "R2 mix");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule